// File: doc/BRIEF.md
# Flash Status Poller

This block is an SPI master that waits on a serial flash device. On a start strobe it pulls chip select low and sends the status-read command once. In high-speed mode it follows the command with one dummy byte. It then keeps clocking in the status byte, which the device sends again and again while chip select stays low. It never sends the command a second time.

Each byte is fully assembled before bit 7 is examined. The first byte with bit 7 set ends the transaction: chip select rises, the byte is latched, and `done` pulses for one cycle. A compare-match flag taken from bit 6 is valid during that pulse.

If no ready byte arrives within a parameterised number of bytes, the poll ends with a timeout flag instead. The user logic can use the block after any self-timed flash operation to wait for completion without running its own SPI sequence.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `done`, `ready`, `timeout` and `cmp_match` are all 0.
- R2: A start accepted while idle drives chip select low and sends the byte 0xD7 on `spi_mosi`, MSB first, in SPI mode 0. `spi_mosi` changes only while `spi_sck` is low, and the device samples it on each rising edge.
- R3: When `hs_mode` is 1 at start, exactly eight zero bits follow the command before any status bit is sampled. When `hs_mode` is 0, status sampling begins with the ninth clock.
- R4: Status bits are sampled from `spi_miso` on the rising edge of `spi_sck`, MSB (bit 7) first, eight bits per byte. Byte after byte is read under the same chip select without resending the command.
- R5: After the first assembled byte whose bit 7 is 1, `spi_cs_n` returns high with no further rising `spi_sck` edge. In the same cycle `done` pulses high for exactly one cycle and `ready` becomes 1.
- R6: `status_byte` holds the last assembled byte with bit 0 forced to 0, because that bit is undefined on the device.
- R7: `cmp_match` is 1 only in the cycle `done` is high, and only when the latched bit 6 is 0.
- R8: If MAX_BYTES bytes in a row all have bit 7 equal to 0, the poll ends after exactly MAX_BYTES bytes. `done` pulses, `timeout` becomes 1 and `ready` stays 0.
- R9: A `start` pulse while a poll is in progress has no effect on the transaction.
- R10: `spi_sck` stays low whenever `spi_cs_n` is high. `busy` is 1 exactly while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll when idle |
| hs_mode | input | 1 | Insert a dummy byte after the command |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| status_byte | output | 8 | Last status byte, bit 0 cleared |
| ready | output | 1 | Poll ended on a ready byte |
| timeout | output | 1 | Poll ended without a ready byte |
| cmp_match | output | 1 | Bit 6 clear, valid with done |
| done | output | 1 | One-cycle end-of-poll pulse |
| busy | output | 1 | Poll in progress |

## Verification
The bench sweeps how many busy bytes come before the ready byte, across both modes and both values of bit 6. The sweep reaches and passes the timeout limit. A byte-alignment slip from a missing or extra dummy byte would make the bench's flash model return shifted data, so the poll would end on the wrong byte. The bench counts rising clock edges under chip select, which exposes a poller that decides on a partial byte or sends one extra clock after the ready byte. The ready bytes carry bit 0 set, which catches a design that forgets to mask it. A start pulse in the middle of each poll would restart the transaction and corrupt the command if it were not ignored.

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int CLK_DIV   = 2,
  parameter int MAX_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       hs_mode,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic [7:0] status_byte,
  output logic       ready,
  output logic       timeout,
  output logic       cmp_match,
  output logic       done,
  output logic       busy
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int BW = $clog2(MAX_BYTES + 1);
  localparam logic [7:0] RD_CMD = 8'hD7;

  logic [DW-1:0] div_q;
  logic [4:0]    bit_q;
  logic [4:0]    hdr_len_q;
  logic          in_hdr_q;
  logic [15:0]   tx_q;
  logic [7:0]    rx_q;
  logic [BW-1:0] nbyte_q;

  wire tick     = (div_q == DW'(CLK_DIV - 1));
  wire fall     = tick && spi_sck;
  wire hdr_end  = in_hdr_q && (bit_q == hdr_len_q - 5'd1);
  wire byte_end = !in_hdr_q && (bit_q == 5'd7);

  assign busy      = !spi_cs_n;
  assign spi_mosi  = !spi_cs_n && in_hdr_q && tx_q[15];
  assign cmp_match = done && !status_byte[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_cs_n    <= 1'b1;
      spi_sck     <= 1'b0;
      div_q       <= '0;
      bit_q       <= '0;
      hdr_len_q   <= 5'd8;
      in_hdr_q    <= 1'b0;
      tx_q        <= '0;
      rx_q        <= '0;
      nbyte_q     <= '0;
      status_byte <= '0;
      ready       <= 1'b0;
      timeout     <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (spi_cs_n) begin
        if (start) begin
          spi_cs_n  <= 1'b0;
          spi_sck   <= 1'b0;
          div_q     <= '0;
          bit_q     <= '0;
          hdr_len_q <= hs_mode ? 5'd16 : 5'd8;
          in_hdr_q  <= 1'b1;
          tx_q      <= {RD_CMD, 8'h00};
          nbyte_q   <= '0;
          ready     <= 1'b0;
          timeout   <= 1'b0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + DW'(1);
        if (tick && !spi_sck) begin
          spi_sck <= 1'b1;
          rx_q    <= {rx_q[6:0], spi_miso};
        end
        if (fall) begin
          spi_sck <= 1'b0;
          bit_q   <= bit_q + 5'd1;
          if (in_hdr_q) tx_q <= {tx_q[14:0], 1'b0};
          if (hdr_end) begin
            in_hdr_q <= 1'b0;
            bit_q    <= '0;
          end
          if (byte_end) begin
            bit_q <= '0;
            if (rx_q[7] || nbyte_q == BW'(MAX_BYTES - 1)) begin
              spi_cs_n    <= 1'b1;
              done        <= 1'b1;
              status_byte <= {rx_q[7:1], 1'b0};
              ready       <= rx_q[7];
              timeout     <= !rx_q[7];
            end else begin
              nbyte_q <= nbyte_q + BW'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_status_poller_chk.sv
module flash_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       ready,
  input logic       timeout,
  input logic       cmp_match,
  input logic       done
);
  // R10
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);
  // R7
  cmp_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |-> done);
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready ^ timeout));
  // R2
  cs_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(start));
endmodule

bind flash_status_poller flash_status_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .spi_cs_n(spi_cs_n),
  .spi_sck(spi_sck), .ready(ready), .timeout(timeout),
  .cmp_match(cmp_match), .done(done)
);

// File: tb/sim_flash_status_poller.sv
`timescale 1ns/1ps
module sim_flash_status_poller;
  localparam int DIV  = 2;
  localparam int MAXB = 6;

  logic clk = 0, rst_n = 0, start = 0, hs_mode = 0;
  logic spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic [7:0] status_byte;
  logic ready, timeout, cmp_match, done, busy;

  int n_chk = 0, n_bad = 0;
  int rises, hdr, busy_n, b6v;
  logic [7:0] cmd;
  logic dummy_bad;

  always #4 clk = ~clk;

  flash_status_poller #(.CLK_DIV(DIV), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .status_byte(status_byte), .ready(ready),
    .timeout(timeout), .cmp_match(cmp_match), .done(done), .busy(busy));

  function automatic logic [7:0] dev_byte(int k);
    if (k < busy_n) return {1'b0, 6'(k * 13 + busy_n), 1'b1};
    return {1'b1, b6v[0], 5'(busy_n * 3 + hdr), 1'b1};
  endfunction

  function automatic logic dev_bit(int idx);
    logic [7:0] b;
    if (idx < hdr) return 1'b0;
    b = dev_byte((idx - hdr) / 8);
    return b[7 - ((idx - hdr) % 8)];
  endfunction

  always @(negedge spi_cs_n) begin
    rises = 0; cmd = 0; dummy_bad = 0;
    spi_miso = dev_bit(0);
  end

  always @(posedge spi_sck) begin
    if (rises < 8) cmd = {cmd[6:0], spi_mosi};
    else if (rises < hdr && spi_mosi) dummy_bad = 1;
    rises = rises + 1;
    spi_miso = dev_bit(rises);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    spi_miso = 0; hdr = 8; busy_n = 0; b6v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 sck", spi_sck, 0);
    check("R1 done", done, 0);
    check("R1 ready", ready, 0);
    check("R1 timeout", timeout, 0);
    check("R1 cmp_match", cmp_match, 0);
    for (int h = 0; h < 2; h++)
      for (int bn = 0; bn < MAXB + 2; bn++)
        for (int c = 0; c < 2; c++) begin
          int nbytes, cyc;
          logic exp_rdy;
          logic [7:0] exp_st;
          hdr = h ? 16 : 8; busy_n = bn; b6v = c;
          exp_rdy = (bn < MAXB);
          nbytes  = exp_rdy ? bn + 1 : MAXB;
          exp_st  = dev_byte(nbytes - 1) & 8'hFE;
          hs_mode = h[0];
          start = 1;
          @(negedge clk);
          start = 0;
          hs_mode = 0;
          check("R10 busy", busy, 1);
          cyc = 0;
          while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 20) start = 1;   // R9: ignored mid-poll
            if (cyc == 21) start = 0;
          end
          check("R5 done seen", done, 1);
          check("R2 opcode", cmd, 8'hD7);
          check("R3 dummy zero", dummy_bad, 0);
          check("R4 clock count", rises, hdr + 8 * nbytes);
          check("R5 cs high", spi_cs_n, 1);
          check("R5 ready", ready, exp_rdy);
          check("R8 timeout", timeout, !exp_rdy);
          check("R6 status", status_byte, exp_st);
          check("R7 cmp_match", cmp_match, exp_rdy ? (c == 0) : !exp_st[6]);
          check("R10 busy low", busy, 0);
          @(negedge clk);
          check("R5 single pulse", done, 0);
          check("R7 cmp low", cmp_match, 0);
          check("R9 no restart", spi_cs_n, 1);
          repeat (2) @(negedge clk);
        end
    finish_run();
  end
endmodule